// File: doc/BRIEF.md
# Legacy INTx Interrupt Pending and Mask Controller

This block gathers four legacy level-style interrupt wires from a PCIe port and turns them into one interrupt request towards the host processor. The four wires arrive as event pulses that an upstream message decoder has already produced, one pulse input per line. Each pulse sets a sticky pending bit. A separate enable mask selects which pending bits may raise the host request.

Software reaches two 32-bit registers over a plain register bus with an address, a write strobe, write data and combinational read data. One register holds the mask and the other holds the pending bits. In both registers the four lines occupy bits 19:16, with line A at bit 16. A pending bit is cleared by writing 1 to it. The host request stays high as long as any enabled pending bit is set, so an interrupt handler can keep reading the status, clearing what it finds, and stop when the enabled pending set is empty.

Top module: `intx_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, mask bits 19:16 read as 1 (all lines disabled), the status register reads 0 and `host_irq` is low.
- R2: A write to address 0x420 loads write-data bits 19:16 into the mask. The next read of 0x420 returns those bits at 19:16.
- R3: An event pulse on `line_event[i]` sets status bit 16+i in the next cycle, whatever the mask holds. It is read at address 0x424.
- R4: A write to 0x424 clears every status bit 19:16 whose write-data bit is 1 and leaves every bit written with 0 unchanged.
- R5: If an event for a line arrives in the same cycle as a write-1-to-clear of that line's status bit, the bit is set after that cycle.
- R6: `host_irq` is 1 exactly when some status bit 16+i is 1 while mask bit 16+i is 0. It follows register changes in the same cycle they become visible on a read.
- R7: Bits outside 19:16 read as 0 at both register addresses and ignore writes. Any other address reads 0, and a write to it changes no state.
- R8: A write to the status address does not change the mask, and a write to the mask address clears no status bit.
- R9: A status bit stays set after its event pulse ends, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| line_event | input | 4 | Decoded assertion pulses, bit 0 = line A |
| host_irq | output | 1 | Aggregated interrupt request |

## Verification
The checker runs on every clock and covers these rules: an event always leaves its bit set (R3, R5), a set bit survives unless it is written with 1 (R9), a 1 written to the status address always clears its bit when no event competes (R4), the mask changes only on a write to its own address (R8), read bits outside the field stay zero (R7), and the request is never high while nothing is pending. Whether the request is high for the right mask and status combination, the reset values, and what a write to an unused address does can only be shown against the bench's reference model. That model follows directed sequences and then a long pseudo-random mix of reads, writes and events.

// File: rtl/intx_irq_pkg.sv
// Package: shared types for the INTx pending/mask controller.
// Assumes: at most one register is addressed per cycle.
package intx_irq_pkg;

    // Which register the bus address selects in this cycle.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/intx_addr_decode.sv
// Module: intx_addr_decode
// Maps a register byte address onto a register select.
// Assumes: MASK_ADDR and STAT_ADDR differ; unmatched addresses select nothing.
module intx_addr_decode
    import intx_irq_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 12'h420,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h424
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Purpose: full-address compare against the two register locations.
    always_comb begin
        if (addr == MASK_ADDR) begin
            sel = SEL_MASK;
        end else if (addr == STAT_ADDR) begin
            sel = SEL_STAT;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/intx_mask_reg.sv
// Module: intx_mask_reg
// Holds the per-line disable mask; a 1 blocks that line from the host request.
// Assumes: wr_en is already qualified by address decode.
module intx_mask_reg #(
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LINES-1:0] wr_bits,
    output logic [LINES-1:0] mask_q
);

    // Purpose: reset to all-masked, then load on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_en) begin
            mask_q <= wr_bits;
        end
    end

endmodule

// File: rtl/intx_pending_cell.sv
// Module: intx_pending_cell
// One sticky pending bit: set by an event pulse, cleared by a write of 1.
// Assumes: set and clear may coincide; set takes priority.
module intx_pending_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_req,
    output logic pend_q
);

    // Purpose: hold the bit; a new event overrides a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set_pulse) begin
            pend_q <= 1'b1;
        end else if (clr_req) begin
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/intx_irq_merge.sv
// Module: intx_irq_merge
// Combines pending bits with the mask into a single request line.
// Assumes: a mask bit of 0 enables its line.
module intx_irq_merge #(
    parameter int LINES = 4
) (
    input  logic [LINES-1:0] pend,
    input  logic [LINES-1:0] mask,
    output logic             irq
);

    logic [LINES-1:0] live;

    // Purpose: keep only the lines that are pending and enabled.
    always_comb begin
        live = pend & ~mask;
    end

    // Purpose: OR the enabled pending lines into one request.
    always_comb begin
        irq = |live;
    end

endmodule

// File: rtl/intx_irq_ctrl.sv
// Module: intx_irq_ctrl (top)
// Pending and mask register pair for the four legacy INTx lines, with one
// aggregated host interrupt request.
// Assumes: line_event carries one-cycle pulses that are already decoded;
// FIELD_LSB + LINES <= DATA_W; the read data is combinational from the address.
module intx_irq_ctrl
    import intx_irq_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int LINES     = 4,
    parameter int FIELD_LSB = 16,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 12'h420,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h424
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LINES-1:0]  line_event,
    output logic              host_irq
);

    localparam int FIELD_MSB = FIELD_LSB + LINES - 1;

    reg_sel_e          sel;
    logic [LINES-1:0]  wr_field;
    logic              mask_wr;
    logic              stat_wr;
    logic [LINES-1:0]  mask_q;
    logic [LINES-1:0]  pend_q;
    logic              unused_wdata;

    // Purpose: the write data outside the field is not stored anywhere.
    assign unused_wdata = ^bus_wdata;

    intx_addr_decode #(
        .ADDR_W    (ADDR_W),
        .MASK_ADDR (MASK_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    // Purpose: extract the line field and qualify the write strobes.
    always_comb begin
        wr_field = bus_wdata[FIELD_MSB:FIELD_LSB];
        mask_wr  = bus_we && (sel == SEL_MASK);
        stat_wr  = bus_we && (sel == SEL_STAT);
    end

    intx_mask_reg #(
        .LINES (LINES)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_wr),
        .wr_bits (wr_field),
        .mask_q  (mask_q)
    );

    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        intx_pending_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_pulse (line_event[gi]),
            .clr_req   (stat_wr && wr_field[gi]),
            .pend_q    (pend_q[gi])
        );
    end

    intx_irq_merge #(
        .LINES (LINES)
    ) u_merge (
        .pend (pend_q),
        .mask (mask_q),
        .irq  (host_irq)
    );

    // Purpose: place the selected register's field; all other bits read zero.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_MASK: bus_rdata[FIELD_MSB:FIELD_LSB] = mask_q;
            SEL_STAT: bus_rdata[FIELD_MSB:FIELD_LSB] = pend_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/intx_irq_ctrl_chk.sv
// Module: intx_irq_ctrl_chk
// Cycle rules for intx_irq_ctrl, bound to every instance of the top module.
// Assumes: it sees the top's ports plus the mask and pending vectors.
module intx_irq_ctrl_chk #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int LINES     = 4,
    parameter int FIELD_LSB = 16,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 12'h420,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h424
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LINES-1:0]  line_event,
    input logic              host_irq,
    input logic [LINES-1:0]  mask,
    input logic [LINES-1:0]  pend
);

    logic [LINES-1:0]  wfield;
    logic              chk_mask_wr;
    logic              chk_stat_wr;
    logic [LINES-1:0]  clr_vec;
    logic [LINES-1:0]  kept;
    logic [LINES-1:0]  race;
    logic [DATA_W-1:0] outside;

    // Purpose: the checker's own decode of the bus, kept apart from the design's.
    always_comb begin
        wfield      = bus_wdata[FIELD_LSB +: LINES];
        chk_mask_wr = bus_we && (bus_addr == MASK_ADDR);
        chk_stat_wr = bus_we && (bus_addr == STAT_ADDR);
        clr_vec     = chk_stat_wr ? wfield : '0;
        kept        = pend & ~clr_vec;
        race        = clr_vec & line_event;
        outside     = '1;
        outside[FIELD_LSB +: LINES] = '0;
    end

    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (line_event != '0) |=> ((pend & $past(line_event)) == $past(line_event)));

    a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        chk_stat_wr |=> ((pend & $past(wfield & ~line_event)) == '0));

    a_r5_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (race != '0) |=> ((pend & $past(race)) == $past(race)));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (kept != '0) |=> ((pend & $past(kept)) == $past(kept)));

    a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_mask_wr |=> $stable(mask));

    a_r7_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata & outside) == '0));

    a_r6_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (pend != '0));

endmodule

bind intx_irq_ctrl intx_irq_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LINES     (LINES),
    .FIELD_LSB (FIELD_LSB),
    .MASK_ADDR (MASK_ADDR),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .line_event (line_event),
    .host_irq   (host_irq),
    .mask       (mask_q),
    .pend       (pend_q)
);

// File: tb/tb_intx_irq_ctrl.sv
// Bench for intx_irq_ctrl: a behavioural reference model that is compared on
// every clock, plus directed checks tagged with their requirements.
module tb_intx_irq_ctrl;

    localparam logic [11:0] A_MASK  = 12'h420;
    localparam logic [11:0] A_STAT  = 12'h424;
    localparam logic [11:0] A_OTHER = 12'h428;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = 12'h000;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [3:0]  line_event = 4'h0;
    logic        host_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // reference model state
    int m_mask = 15;
    int m_pend = 0;

    always #10 clk = ~clk;

    intx_irq_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .line_event (line_event),
        .host_irq   (host_irq)
    );

    // model update at the clock edge, from the inputs held since mid-cycle
    always @(posedge clk) begin
        int clr;
        if (!rst_n) begin
            m_mask = 15;
            m_pend = 0;
        end else begin
            clr = 0;
            if (bus_we && bus_addr == A_MASK) m_mask = (bus_wdata >> 16) & 15;
            if (bus_we && bus_addr == A_STAT) clr = (bus_wdata >> 16) & 15;
            m_pend = (m_pend & ~clr) | int'(line_event);
        end
    end

    function automatic logic [31:0] model_read(logic [11:0] a);
        if (a == A_MASK) return 32'(m_mask << 16);
        if (a == A_STAT) return 32'(m_pend << 16);
        return 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // every-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(bus_addr == A_MASK ? "R2 read" : (bus_addr == A_STAT ? "R3 read" : "R7 read"),
                  bus_rdata, model_read(bus_addr));
            check("R6 irq", 32'(host_irq), 32'(((m_pend & ~m_mask) & 15) != 0));
        end
    end

    task automatic cyc(logic [11:0] a, logic we, logic [31:0] wd, logic [3:0] ev);
        @(posedge clk);
        #5;
        bus_addr   = a;
        bus_we     = we;
        bus_wdata  = wd;
        line_event = ev;
    endtask

    task automatic peek(logic [11:0] a, output logic [31:0] v);
        cyc(a, 1'b0, 32'h0, 4'h0);
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;

        // R1 reset values
        peek(A_MASK, v);  check("R1 mask", v, 32'h000F_0000);
        peek(A_STAT, v);  check("R1 stat", v, 32'h0);
        check("R1 irq", 32'(host_irq), 32'h0);

        // R3 event on line C while masked
        cyc(A_STAT, 1'b0, 32'h0, 4'h4);
        peek(A_STAT, v);  check("R3 set", v, 32'h0004_0000);
        check("R6 masked", 32'(host_irq), 32'h0);

        // R9 sticky
        repeat (4) cyc(A_OTHER, 1'b0, 32'h0, 4'h0);
        peek(A_STAT, v);  check("R9 sticky", v, 32'h0004_0000);

        // R2 unmask all
        cyc(A_MASK, 1'b1, 32'h0, 4'h0);
        peek(A_MASK, v);  check("R2 mask", v, 32'h0);
        check("R6 unmasked", 32'(host_irq), 32'h1);

        // R4 writing zeros keeps the bit
        cyc(A_STAT, 1'b1, 32'hFFF0_FFFF, 4'h0);
        peek(A_STAT, v);  check("R4 zero write", v, 32'h0004_0000);
        cyc(A_STAT, 1'b1, 32'h0004_0000, 4'h0);
        peek(A_STAT, v);  check("R4 clear", v, 32'h0);
        check("R6 drop", 32'(host_irq), 32'h0);

        // R5 event beats clear
        cyc(A_STAT, 1'b1, 32'h0001_0000, 4'h1);
        peek(A_STAT, v);  check("R5 race", v, 32'h0001_0000);

        // R4 selective clear
        cyc(A_STAT, 1'b0, 32'h0, 4'hA);
        peek(A_STAT, v);  check("R3 multi", v, 32'h000B_0000);
        cyc(A_STAT, 1'b1, 32'h0002_0000, 4'h0);
        peek(A_STAT, v);  check("R4 one bit", v, 32'h0009_0000);

        // R6 mask selection
        cyc(A_MASK, 1'b1, 32'h000F_0000, 4'h0);
        peek(A_MASK, v);  check("R6 all masked irq", 32'(host_irq), 32'h0);
        cyc(A_MASK, 1'b1, 32'h0007_0000, 4'h0);
        peek(A_MASK, v);  check("R6 line D only", 32'(host_irq), 32'h1);

        // R7 other bits and other address
        cyc(A_MASK, 1'b1, 32'hFFF5_FFFF, 4'h0);
        peek(A_MASK, v);  check("R7 mask bits", v, 32'h0005_0000);
        cyc(A_OTHER, 1'b1, 32'hFFFF_FFFF, 4'h0);
        peek(A_OTHER, v); check("R7 other addr", v, 32'h0);
        peek(A_MASK, v);  check("R7 mask kept", v, 32'h0005_0000);
        peek(A_STAT, v);  check("R7 stat kept", v, 32'h0009_0000);

        // R8 cross-register isolation
        cyc(A_STAT, 1'b1, 32'h000F_0000, 4'h0);
        peek(A_MASK, v);  check("R8 mask after stat write", v, 32'h0005_0000);
        cyc(A_STAT, 1'b0, 32'h0, 4'h3);
        cyc(A_MASK, 1'b1, 32'h000F_0000, 4'h0);
        peek(A_STAT, v);  check("R8 stat after mask write", v, 32'h0003_0000);

        // pseudo-random mix, compared by the every-cycle model check
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 2000; i++) begin
            logic [11:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = (lfsr[1:0] == 2'd0) ? A_MASK : ((lfsr[1:0] == 2'd3) ? A_OTHER : A_STAT);
            cyc(a, lfsr[5], {lfsr[15:8], lfsr[23:20], lfsr[19:0]},
                lfsr[7] ? lfsr[27:24] : 4'h0);
        end
        cyc(A_STAT, 1'b0, 32'h0, 4'h0);
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule